// File: doc/BRIEF.md
# Priority Throttle Arbiter with Clock Pulse Skippers

This block resolves several concurrent throttle requests (light thermal, heavy thermal and a first overcurrent source) into one set of throttle settings. Each request slot carries a programmable priority, a CPU skip percentage and a two-bit GPU skip level, loaded through a small write port. Among the active requests, the one with the largest priority wins. Ties go to the lowest slot index.

The winning settings drive two pulse skippers. One thins a CPU clock-enable and the other thins a GPU clock-enable, each dropping a fixed count of enable pulses in every 100-cycle window. A free-running window counter samples the arbitration result in the last cycle of each window, so the skip pattern and the reported winner change only on window boundaries.

Slot order is light = 0, heavy = 1, overcurrent = 2.

Top module: `throttle_arbiter`

## Requirements
- R1: After reset, all slots hold priority 1, CPU percentage 0 and GPU level 0. In the first window after reset, `win_vld_o` is 0, `win_idx_o` is 0, and both enables are 1 in every cycle.
- R2: In a window where no request was active at the preceding boundary, `win_vld_o` is 0 and both enables stay 1 for all 100 cycles.
- R3: With a single active slot, `cpu_en_o` is 0 in exactly P cycles of each 100-cycle window, where P is that slot's CPU percentage. P = 0 drops nothing.
- R4: The GPU level code maps to dropped pulses per window as follows: code 0 drops 0, code 1 drops 50, code 2 drops 75 and code 3 drops 85.
- R5: When several slots are active, `win_idx_o` names the active slot with the numerically largest priority, `win_vld_o` is 1, and both skippers use that slot's settings.
- R6: Among active slots that share the largest priority, the lowest index wins.
- R7: Requests and settings are sampled only at the clock edge that ends a window. A request change in mid-window leaves that window's drop counts and `win_idx_o`/`win_vld_o` unchanged. The change shows from the first cycle of the next window.
- R8: A CPU percentage written above 100 is stored as 100. At a depth of 100, `cpu_en_o` is 0 in every cycle of the window.
- R9: Drops are spread evenly. At a depth of 50 or less, no two adjacent cycles are both dropped. At a depth of 50 or more, no two adjacent cycles both pass.
- R10: A write with `cfg_we_i` = 1 updates the slot `cfg_sel_i` on the next edge. The field is chosen by `cfg_fld_i`: 0 for priority, 1 for CPU percentage, 2 for GPU level (data bits 1:0). Field code 3, or a slot index of `N_REQ` or more, changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_REQ | Throttle request lines, one per slot |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | IDX_W | Slot addressed by the write |
| cfg_fld_i | input | 2 | Field select (0 priority, 1 CPU %, 2 GPU level, 3 none) |
| cfg_data_i | input | 7 | Write data |
| cpu_en_o | output | 1 | Thinned CPU clock-enable |
| gpu_en_o | output | 1 | Thinned GPU clock-enable |
| win_vld_o | output | 1 | A winner is applied in the current window |
| win_idx_o | output | IDX_W | Index of the applied winner |

## Verification
- **Sampling point.** Requests and configuration are sampled at the edge that moves the window counter from 99 to 0. The winner, its index and the new skip depth are therefore visible in the first cycle of the following window, with no further latency.
- **Enable timing.** The enables are decoded combinationally from the registered accumulator, so each cycle's drop decision is visible in that same cycle.
- **Bench alignment.** The bench keeps its own window count from reset release. It applies every stimulus well before a boundary edge and then measures one whole window on falling edges. It counts drops and runs of adjacent drops or passes, and checks that the winner stays constant across the window.
- **Mid-window changes.** For mid-window changes, the bench checks the old results for the rest of that window and the new winner on the first falling edge after the boundary.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int WND_LEN = 100;
  localparam int PCT_W   = 7;
  localparam int PRIO_W  = 7;
  localparam int ACC_W   = PCT_W + 1;
  localparam int CNT_W   = $clog2(WND_LEN);

  typedef enum logic [1:0] {
    FLD_PRIO = 2'd0,
    FLD_CPU  = 2'd1,
    FLD_GPU  = 2'd2,
    FLD_NONE = 2'd3
  } fld_e;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic [PCT_W-1:0]  cpu_pct;
    logic [1:0]        gpu_lvl;
  } slot_cfg_t;

  function automatic logic [PCT_W-1:0] gpu_lvl_pct(input logic [1:0] lvl);
    case (lvl)
      2'd0:    return PCT_W'(0);
      2'd1:    return PCT_W'(50);
      2'd2:    return PCT_W'(75);
      default: return PCT_W'(85);
    endcase
  endfunction
endpackage

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs
  import thr_pkg::*;
#(
  parameter int N_REQ = 3,
  parameter int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       sel_i,
  input  logic [1:0]             fld_i,
  input  logic [PCT_W-1:0]       data_i,
  output slot_cfg_t [N_REQ-1:0]  cfg_o
);
  logic [PCT_W-1:0] pct_sat;
  assign pct_sat = (data_i > PCT_W'(WND_LEN)) ? PCT_W'(WND_LEN) : data_i;

  for (genvar g = 0; g < N_REQ; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[g].prio    <= PRIO_W'(1);
        cfg_o[g].cpu_pct <= '0;
        cfg_o[g].gpu_lvl <= '0;
      end else if (we_i && sel_i == IDX_W'(g)) begin
        case (fld_e'(fld_i))
          FLD_PRIO: cfg_o[g].prio    <= PRIO_W'(data_i);
          FLD_CPU:  cfg_o[g].cpu_pct <= pct_sat;
          FLD_GPU:  cfg_o[g].gpu_lvl <= data_i[1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/thr_prio_arb.sv
module thr_prio_arb
  import thr_pkg::*;
#(
  parameter int N_REQ = 3,
  parameter int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0]       req_i,
  input  slot_cfg_t [N_REQ-1:0]  cfg_i,
  output logic                   vld_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic [PRIO_W-1:0] best;

  // strict compare keeps the lowest index on ties
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    best  = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req_i[i] && (!vld_o || cfg_i[i].prio > best)) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(i);
        best  = cfg_i[i].prio;
      end
    end
  end
endmodule

// File: rtl/thr_skipper.sv
module thr_skipper
  import thr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wnd_first_i,
  input  logic [PCT_W-1:0] depth_i,
  output logic             pass_o
);
  logic [ACC_W-1:0] acc_q, acc_sum;
  logic             drop;

  // restart at window start so each window drops exactly depth_i
  assign acc_sum = (wnd_first_i ? '0 : acc_q) + ACC_W'(depth_i);
  assign drop    = acc_sum >= ACC_W'(WND_LEN);
  assign pass_o  = !drop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (drop) acc_q <= acc_sum - ACC_W'(WND_LEN);
    else           acc_q <= acc_sum;
  end
endmodule

// File: rtl/throttle_arbiter.sv
module throttle_arbiter
  import thr_pkg::*;
#(
  parameter int N_REQ = 3,
  parameter int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_sel_i,
  input  logic [1:0]       cfg_fld_i,
  input  logic [PCT_W-1:0] cfg_data_i,
  output logic             cpu_en_o,
  output logic             gpu_en_o,
  output logic             win_vld_o,
  output logic [IDX_W-1:0] win_idx_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WND_LEN - 1);

  slot_cfg_t [N_REQ-1:0] cfg;
  logic                  arb_vld;
  logic [IDX_W-1:0]      arb_idx;
  logic [CNT_W-1:0]      wnd_cnt_q;
  logic                  wnd_first, wnd_last;
  logic [PCT_W-1:0]      cpu_depth_q, gpu_depth_q;
  logic                  win_vld_q;
  logic [IDX_W-1:0]      win_idx_q;

  thr_cfg_regs #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .sel_i  (cfg_sel_i),
    .fld_i  (cfg_fld_i),
    .data_i (cfg_data_i),
    .cfg_o  (cfg)
  );

  thr_prio_arb #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_arb (
    .req_i (req_i),
    .cfg_i (cfg),
    .vld_o (arb_vld),
    .idx_o (arb_idx)
  );

  assign wnd_first = (wnd_cnt_q == '0);
  assign wnd_last  = (wnd_cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wnd_cnt_q <= '0;
    else if (wnd_last) wnd_cnt_q <= '0;
    else               wnd_cnt_q <= wnd_cnt_q + CNT_W'(1);
  end

  // arbitration result is applied only across a window boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_vld_q   <= 1'b0;
      win_idx_q   <= '0;
      cpu_depth_q <= '0;
      gpu_depth_q <= '0;
    end else if (wnd_last) begin
      win_vld_q   <= arb_vld;
      win_idx_q   <= arb_idx;
      cpu_depth_q <= arb_vld ? cfg[arb_idx].cpu_pct : '0;
      gpu_depth_q <= arb_vld ? gpu_lvl_pct(cfg[arb_idx].gpu_lvl) : '0;
    end
  end

  thr_skipper u_cpu_skip (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wnd_first_i (wnd_first),
    .depth_i     (cpu_depth_q),
    .pass_o      (cpu_en_o)
  );

  thr_skipper u_gpu_skip (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wnd_first_i (wnd_first),
    .depth_i     (gpu_depth_q),
    .pass_o      (gpu_en_o)
  );

  assign win_vld_o = win_vld_q;
  assign win_idx_o = win_idx_q;
endmodule

// File: rtl/thr_arbiter_chk.sv
module thr_arbiter_chk
  import thr_pkg::*;
#(
  parameter int N_REQ = 3,
  parameter int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_REQ-1:0] req_i,
  input logic             cpu_en_o,
  input logic             gpu_en_o,
  input logic             win_vld_o,
  input logic [IDX_W-1:0] win_idx_o,
  input logic [CNT_W-1:0] wnd_cnt_i,
  input logic [PCT_W-1:0] cpu_depth_i
);
  logic [N_REQ-1:0] req_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_i;
  end

  AST_IDLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_vld_o |-> (cpu_en_o && gpu_en_o)); // R2

  AST_WIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wnd_cnt_i != '0) |-> ($stable(win_idx_o) && $stable(win_vld_o))); // R7

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld_o |-> (win_idx_o < IDX_W'(N_REQ))); // R5

  AST_WINNER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wnd_cnt_i == '0 && win_vld_o) |-> req_q[win_idx_o]); // R5

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_depth_i == PCT_W'(WND_LEN)) |-> !cpu_en_o); // R8

  AST_ZERO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_depth_i == '0) |-> cpu_en_o); // R3

  AST_DEPTH_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_depth_i <= PCT_W'(WND_LEN)); // R8
endmodule

bind throttle_arbiter thr_arbiter_chk #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .cpu_en_o    (cpu_en_o),
  .gpu_en_o    (gpu_en_o),
  .win_vld_o   (win_vld_o),
  .win_idx_o   (win_idx_o),
  .wnd_cnt_i   (wnd_cnt_q),
  .cpu_depth_i (cpu_depth_q)
);

// File: tb/throttle_arbiter_bench.sv
module throttle_arbiter_bench;
  localparam int N_REQ = 3;
  localparam int IDX_W = 2;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_REQ-1:0] req = '0;
  logic             we = 1'b0;
  logic [IDX_W-1:0] sel = '0;
  logic [1:0]       fld = '0;
  logic [6:0]       data = '0;
  logic             cpu_en_o, gpu_en_o, win_vld_o;
  logic [IDX_W-1:0] win_idx_o;

  int n_chk = 0, n_fail = 0;
  int b_cnt = 0;
  bit done = 0;

  // window result record
  logic             w_vld, w_stable;
  logic [IDX_W-1:0] w_idx;
  int c_drop, g_drop, c_maxd, c_maxp, g_maxd, g_maxp;

  always #10ns clk_i = ~clk_i; // 50 MHz

  throttle_arbiter #(.N_REQ(N_REQ)) u_throttle_arbiter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .cfg_we_i   (we),
    .cfg_sel_i  (sel),
    .cfg_fld_i  (fld),
    .cfg_data_i (data),
    .cpu_en_o   (cpu_en_o),
    .gpu_en_o   (gpu_en_o),
    .win_vld_o  (win_vld_o),
    .win_idx_o  (win_idx_o)
  );

  // bench-side window position, counted from reset release
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) b_cnt <= 0;
    else         b_cnt <= (b_cnt == 99) ? 0 : b_cnt + 1;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic cfg_wr(input int s, input int f, input int d);
    @(negedge clk_i);
    we = 1'b1; sel = IDX_W'(s); fld = 2'(f); data = 7'(d);
    @(negedge clk_i);
    we = 1'b0;
  endtask

  // measure one full window that starts after mid-window (stimulus is settled)
  task automatic run_window(input int chg_at, input logic [N_REQ-1:0] chg_req);
    int cd, cp, gd, gp;
    @(negedge clk_i);
    while (b_cnt != 50) @(negedge clk_i);
    while (b_cnt != 0) @(negedge clk_i);
    w_vld = win_vld_o; w_idx = win_idx_o; w_stable = 1'b1;
    c_drop = 0; g_drop = 0; c_maxd = 0; c_maxp = 0; g_maxd = 0; g_maxp = 0;
    cd = 0; cp = 0; gd = 0; gp = 0;
    for (int k = 0; k < 100; k++) begin
      if (k > 0) @(negedge clk_i);
      if (win_vld_o !== w_vld || win_idx_o !== w_idx) w_stable = 1'b0;
      if (!cpu_en_o) begin c_drop++; cd++; cp = 0; end else begin cp++; cd = 0; end
      if (!gpu_en_o) begin g_drop++; gd++; gp = 0; end else begin gp++; gd = 0; end
      if (cd > c_maxd) c_maxd = cd;
      if (cp > c_maxp) c_maxp = cp;
      if (gd > g_maxd) g_maxd = gd;
      if (gp > g_maxp) g_maxp = gp;
      if (k == chg_at) req = chg_req;
    end
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; req = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(win_vld_o == 1'b0, "R1 vld after reset", win_vld_o, 0);
    chk(win_idx_o == '0, "R1 idx after reset", win_idx_o, 0);
    chk(cpu_en_o && gpu_en_o, "R1 enables after reset", {cpu_en_o, gpu_en_o}, 3);
    // default slots: request slot 0 with reset config, expect no drops
    req = 3'b001;
    run_window(-1, '0);
    chk(c_drop == 0, "R1 default cpu pct 0", c_drop, 0);
    chk(g_drop == 0, "R1 default gpu lvl 0", g_drop, 0);
  endtask

  task automatic t_setup;
    cfg_wr(0, 0, 80); cfg_wr(0, 1, 50); cfg_wr(0, 2, 1);
    cfg_wr(1, 0, 100); cfg_wr(1, 1, 85); cfg_wr(1, 2, 3);
    cfg_wr(2, 0, 50); cfg_wr(2, 1, 75); cfg_wr(2, 2, 2);
  endtask

  task automatic t_idle;
    req = '0;
    run_window(-1, '0);
    chk(w_vld == 1'b0, "R2 no winner", w_vld, 0);
    chk(c_drop == 0, "R2 cpu drops", c_drop, 0);
    chk(g_drop == 0, "R2 gpu drops", g_drop, 0);
  endtask

  task automatic t_single;
    req = 3'b001;
    run_window(-1, '0);
    chk(w_vld && w_idx == 0, "R3 light winner", w_idx, 0);
    chk(c_drop == 50, "R3 light cpu drops", c_drop, 50);
    chk(g_drop == 50, "R4 level 1 drops", g_drop, 50);
    chk(c_maxd == 1, "R9 cpu 50 no adjacent drops", c_maxd, 1);
    req = 3'b100;
    run_window(-1, '0);
    chk(w_idx == 2, "R3 oc winner", w_idx, 2);
    chk(c_drop == 75, "R3 oc cpu drops", c_drop, 75);
    chk(g_drop == 75, "R4 level 2 drops", g_drop, 75);
    chk(c_maxp == 1, "R9 cpu 75 no adjacent passes", c_maxp, 1);
  endtask

  task automatic t_prio;
    req = 3'b011;
    run_window(-1, '0);
    chk(w_idx == 1, "R5 heavy over light", w_idx, 1);
    chk(c_drop == 85, "R5 heavy cpu drops", c_drop, 85);
    chk(g_drop == 85, "R4 level 3 drops", g_drop, 85);
    chk(g_maxp == 1, "R9 gpu 85 no adjacent passes", g_maxp, 1);
    req = 3'b111;
    run_window(-1, '0);
    chk(w_idx == 1, "R5 heavy over all", w_idx, 1);
    req = 3'b101;
    run_window(-1, '0);
    chk(w_idx == 0, "R5 light over oc", w_idx, 0);
    chk(c_drop == 50, "R5 light cpu with oc", c_drop, 50);
  endtask

  task automatic t_gpu0;
    cfg_wr(0, 2, 0);
    req = 3'b001;
    run_window(-1, '0);
    chk(g_drop == 0, "R4 level 0 drops", g_drop, 0);
    cfg_wr(0, 2, 1);
  endtask

  task automatic t_tie;
    cfg_wr(2, 0, 80);
    req = 3'b101;
    run_window(-1, '0);
    chk(w_idx == 0, "R6 tie light vs oc", w_idx, 0);
    cfg_wr(2, 0, 100);
    req = 3'b111;
    run_window(-1, '0);
    chk(w_idx == 1, "R6 tie heavy vs oc", w_idx, 1);
    cfg_wr(2, 0, 101);
    run_window(-1, '0);
    chk(w_idx == 2, "R10 prio write takes effect", w_idx, 2);
    cfg_wr(2, 0, 50);
  endtask

  task automatic t_boundary;
    req = 3'b001;
    run_window(50, 3'b010);
    chk(w_stable == 1'b1, "R7 winner stable in window", w_stable, 1);
    chk(w_idx == 0, "R7 old winner kept", w_idx, 0);
    chk(c_drop == 50, "R7 old cpu depth kept", c_drop, 50);
    @(negedge clk_i);
    chk(b_cnt == 0 && win_idx_o == 1, "R7 new winner at boundary", win_idx_o, 1);
  endtask

  task automatic t_clamp;
    cfg_wr(0, 1, 127);
    req = 3'b001;
    run_window(-1, '0);
    chk(c_drop == 100, "R8 cpu clamp to 100", c_drop, 100);
    cfg_wr(0, 1, 0);
    run_window(-1, '0);
    chk(c_drop == 0, "R3 cpu pct 0", c_drop, 0);
    cfg_wr(0, 1, 50);
  endtask

  task automatic t_ignore;
    cfg_wr(0, 3, 0);
    cfg_wr(3, 0, 127);
    req = 3'b001;
    run_window(-1, '0);
    chk(c_drop == 50, "R10 field 3 ignored cpu", c_drop, 50);
    chk(g_drop == 50, "R10 field 3 ignored gpu", g_drop, 50);
    req = 3'b011;
    run_window(-1, '0);
    chk(w_idx == 1, "R10 prio unchanged", w_idx, 1);
  endtask

  initial begin
    t_reset();
    t_setup();
    t_idle();
    t_single();
    t_prio();
    t_gpu0();
    t_tie();
    t_boundary();
    t_clamp();
    t_ignore();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule